// File: doc/BRIEF.md
# Interrupt Redirection Register Block

This block holds the configuration state of an I/O interrupt router. The host reaches it through two 32-bit bus locations. One is an index register that selects an internal register. The other is a data window that reads or writes the register the index selects. Behind the window sit the following registers:

- an 8-bit identifier
- a read-only version word that also reports the table size
- an 8-bit arbitration identifier
- a table of 64-bit redirection entries, each exposed as two 32-bit halves

The stored entry fields leave the block as flat per-entry vectors for the routing logic. A bus read returns its data one cycle after the request. An access to an offset that is neither the index nor the window returns zero and raises a one-cycle error pulse. Reserved bits of an entry are cleared whenever a half is written, so they always read back as zero.

Top module: `irq_redir_regs`

## Requirements
- R1: After reset the index register is 0, the identifier and the arbitration identifier both equal INIT_ID, and every entry reads back 0x00010000 in its low half and 0 in its high half (mask set, all else clear). bus_err is 0.
- R2: A write to bus offset 0 stores wdata[7:0] as the index. A read of offset 0 returns the index zero-extended to 32 bits.
- R3: bus_rdata and bus_err for a request presented in one cycle are valid in the following cycle. A write request returns bus_rdata of 0.
- R4: Index 0 through the window (offset 16) is the identifier. It reads as {id, 24'h0}, and a write loads id from wdata[31:24].
- R5: Index 1 is read-only and reads as {8'h00, NUM_ENTRIES-1, 8'h00, VERSION}, with VERSION defaulting to 0x11. A write to it changes no register.
- R6: Index 2 is the arbitration identifier. It reads as {arb, 24'h0} and loads arb from wdata[31:24].
- R7: Entry n uses index 0x10+2n for bits 31:0 and index 0x10+2n+1 for bits 63:32.
- R8: A write to a low half keeps only the bits in 0x0001AFFF. A write to a high half keeps only the bits in 0xFF000000. All other bits read as zero.
- R9: The entry fields are vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], trigger [15], mask [16] and destination [63:56]. They appear on the per-entry outputs in the cycle after the write.
- R10: Indices 3..0x0F and indices from 0x10+2*NUM_ENTRIES up to 0xFF read as zero through the window, and writes to them change no register.
- R11: Any bus offset other than 0 and 16 reads as zero, changes no register, and pulses bus_err for exactly the following cycle. Legal offsets never raise bus_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Illegal-offset pulse, registered |
| vec_o | output | NUM_ENTRIES*8 | Vector per entry |
| dlv_o | output | NUM_ENTRIES*3 | Delivery mode per entry |
| dmode_o | output | NUM_ENTRIES | Destination mode per entry |
| pol_o | output | NUM_ENTRIES | Polarity per entry |
| trig_o | output | NUM_ENTRIES | Trigger per entry |
| mask_o | output | NUM_ENTRIES | Mask per entry |
| dest_o | output | NUM_ENTRIES*8 | Destination per entry |

## Verification
Every result of this block is due one clock after its request:
- read data and the error pulse come from registers loaded at the edge that accepts the request;
- a written entry field reaches its output at that same edge.

The bench presents each request at a falling edge. It samples bus_rdata, bus_err and all entry outputs at the next falling edge, when that one register stage has settled. It then presents the next request. As a result, each check compares the cycle directly after its request against the reference model.

// File: rtl/irq_redir_regs.sv
module irq_redir_regs #(
  parameter int          NUM_ENTRIES = 24,
  parameter logic [7:0]  VERSION     = 8'h11,
  parameter logic [7:0]  INIT_ID     = 8'h05,
  parameter int          ADDR_W      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       bus_err,
  output logic [NUM_ENTRIES*8-1:0]   vec_o,
  output logic [NUM_ENTRIES*3-1:0]   dlv_o,
  output logic [NUM_ENTRIES-1:0]     dmode_o,
  output logic [NUM_ENTRIES-1:0]     pol_o,
  output logic [NUM_ENTRIES-1:0]     trig_o,
  output logic [NUM_ENTRIES-1:0]     mask_o,
  output logic [NUM_ENTRIES*8-1:0]   dest_o
);
  localparam int          TBL_END = 16 + 2 * NUM_ENTRIES;
  localparam logic [31:0] LO_KEEP = 32'h0001_AFFF;
  localparam logic [31:0] LO_RST  = 32'h0001_0000;
  localparam logic [7:0]  CNT_M1  = 8'(NUM_ENTRIES - 1);
  localparam logic [ADDR_W-1:0] OFF_SEL = '0;
  localparam logic [ADDR_W-1:0] OFF_WIN = ADDR_W'(16);

  logic [7:0]  sel_q, id_q, arb_q;
  logic [31:0] lo_q  [NUM_ENTRIES];
  logic [7:0]  dst_q [NUM_ENTRIES];
  logic [31:0] rd_mux;

  wire hit_sel = bus_valid && (bus_addr == OFF_SEL);
  wire hit_win = bus_valid && (bus_addr == OFF_WIN);
  wire illegal = bus_valid && !hit_sel && !hit_win;
  wire win_wr  = hit_win && bus_write;

  wire [7:0] ent_off = sel_q - 8'h10;
  wire [6:0] ent_idx = ent_off[7:1];
  wire       is_tbl  = (sel_q >= 8'h10) && (int'(sel_q) < TBL_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= INIT_ID;
      arb_q <= INIT_ID;
    end else begin
      if (hit_sel && bus_write) sel_q <= bus_wdata[7:0];
      if (win_wr && sel_q == 8'd0) id_q  <= bus_wdata[31:24];
      if (win_wr && sel_q == 8'd2) arb_q <= bus_wdata[31:24];
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    wire hit = win_wr && is_tbl && (ent_idx == 7'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[i]  <= LO_RST;
        dst_q[i] <= '0;
      end else if (hit) begin
        if (sel_q[0]) dst_q[i] <= bus_wdata[31:24];
        else          lo_q[i]  <= bus_wdata & LO_KEEP;
      end
    end
    assign vec_o[i*8 +: 8]  = lo_q[i][7:0];
    assign dlv_o[i*3 +: 3]  = lo_q[i][10:8];
    assign dmode_o[i]       = lo_q[i][11];
    assign pol_o[i]         = lo_q[i][13];
    assign trig_o[i]        = lo_q[i][15];
    assign mask_o[i]        = lo_q[i][16];
    assign dest_o[i*8 +: 8] = dst_q[i];
  end

  always_comb begin
    rd_mux = '0;
    if (hit_sel) rd_mux = {24'h0, sel_q};
    else if (hit_win) begin
      case (sel_q)
        8'd0:    rd_mux = {id_q, 24'h0};
        8'd1:    rd_mux = {8'h00, CNT_M1, 8'h00, VERSION};
        8'd2:    rd_mux = {arb_q, 24'h0};
        default: if (is_tbl) rd_mux = sel_q[0] ? {dst_q[ent_idx], 24'h0} : lo_q[ent_idx];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= (bus_valid && !bus_write) ? rd_mux : 32'h0;
      bus_err   <= illegal;
    end
  end

  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_sel && bus_write |=> sel_q == $past(bus_wdata[7:0]));
  // R4
  id_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr && sel_q == 8'd0 |=> id_q == $past(bus_wdata[31:24]));
  // R5
  version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_win && !bus_write && sel_q == 8'd1 |=> bus_rdata[23:16] == CNT_M1 && bus_rdata[7:0] == VERSION);
  // R10
  undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr && sel_q > 8'd2 && int'(sel_q) >= TBL_END |=> $stable(mask_o) && $stable(dest_o) && $stable(vec_o));
  // R11
  illegal_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> bus_err && bus_rdata == 32'h0 && $stable(sel_q));
  // R11
  legal_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |=> !bus_err);
endmodule

// File: tb/tb_irq_redir_regs.sv
module tb_irq_redir_regs;
  localparam int N = 24;
  localparam logic [7:0] INIT = 8'h05;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_err;
  logic [N*8-1:0] vec_o, dest_o;
  logic [N*3-1:0] dlv_o;
  logic [N-1:0] dmode_o, pol_o, trig_o, mask_o;

  irq_redir_regs dut (.clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
    .bus_rdata, .bus_err, .vec_o, .dlv_o, .dmode_o, .pol_o, .trig_o, .mask_o, .dest_o);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] m_sel, m_id, m_arb;
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] s);
    if (s == 0) return {m_id, 24'h0};
    if (s == 1) return {8'h00, 8'(N-1), 8'h00, 8'h11};
    if (s == 2) return {m_arb, 24'h0};
    if (s >= 8'h10 && int'(s) < 16 + 2*N)
      return s[0] ? m_hi[(s-8'h10)>>1] : m_lo[(s-8'h10)>>1];
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [7:0] s);
    if (s == 0) return "R4";
    if (s == 1) return "R5";
    if (s == 2) return "R6";
    if (s >= 8'h10 && int'(s) < 16 + 2*N) return "R7";
    return "R10";
  endfunction

  task automatic model_reset();
    m_sel = 0; m_id = INIT; m_arb = INIT;
    for (int i = 0; i < N; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = 0; end
  endtask

  task automatic check_fields();
    bit ok = 1;
    for (int i = 0; i < N; i++) begin
      if (vec_o[i*8+:8] != m_lo[i][7:0] || dlv_o[i*3+:3] != m_lo[i][10:8] ||
          dmode_o[i] != m_lo[i][11] || pol_o[i] != m_lo[i][13] ||
          trig_o[i] != m_lo[i][15] || mask_o[i] != m_lo[i][16] ||
          dest_o[i*8+:8] != m_hi[i][31:24]) begin
        if (ok) check(0, $sformatf("R9 entry %0d", i), {vec_o[i*8+:8], dest_o[i*8+:8], 7'h0, mask_o[i], 8'h0},
                      {m_lo[i][7:0], m_hi[i][31:24], 7'h0, m_lo[i][16], 8'h0});
        ok = 0;
      end
    end
    if (ok) check(1, "R9", 0, 0);
  endtask

  task automatic access(input bit wr, input logic [7:0] addr, input logic [31:0] data);
    logic [31:0] exp = 0;
    bit ill = (addr != 0 && addr != 16);
    string t;
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = addr; bus_wdata = data;
    if (!wr && addr == 0) exp = {24'h0, m_sel};
    else if (!wr && addr == 16) exp = exp_read(m_sel);
    t = ill ? "R11" : (addr == 0 ? "R2" : tag_of(m_sel));
    if (wr && addr == 0) m_sel = data[7:0];
    else if (wr && addr == 16) begin
      if (m_sel == 0) m_id = data[31:24];
      else if (m_sel == 2) m_arb = data[31:24];
      else if (m_sel >= 8'h10 && int'(m_sel) < 16 + 2*N) begin
        if (m_sel[0]) m_hi[(m_sel-8'h10)>>1] = data & 32'hFF00_0000;
        else          m_lo[(m_sel-8'h10)>>1] = data & 32'h0001_AFFF;
      end
    end
    @(negedge clk);
    bus_valid = 0;
    check(bus_rdata == exp, {t, " R3 rdata"}, bus_rdata, exp);
    check(bus_err == ill, "R11 err", {31'h0, bus_err}, {31'h0, ill});
    check_fields();
  endtask

  task automatic rd_win(input logic [7:0] s);
    access(1, 0, {24'h0, s});
    access(0, 16, 0);
  endtask

  task automatic wr_win(input logic [7:0] s, input logic [31:0] d);
    access(1, 0, {24'h0, s});
    access(1, 16, d);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(bus_err == 0, "R1 err", {31'h0, bus_err}, 0);
    check_fields();
    access(0, 0, 0);
    for (int s = 0; s < 3; s++) rd_win(8'(s));
    rd_win(8'h10); rd_win(8'h11); rd_win(8'h3F);
    // R5 read-only version
    wr_win(1, 32'hFFFF_FFFF); access(0, 16, 0);
    // R8 scrub on both halves, first and last entry
    wr_win(8'h10, 32'hFFFF_FFFF); access(0, 16, 0);
    wr_win(8'h11, 32'hFFFF_FFFF); access(0, 16, 0);
    wr_win(8'h3E, 32'hFFFF_FFFF); access(0, 16, 0);
    wr_win(8'h3F, 32'h12FF_FFFF); access(0, 16, 0);
    // R10 undefined indices: just past table, gap, top
    wr_win(8'h40, 32'hFFFF_FFFF); access(0, 16, 0);
    wr_win(8'h03, 32'hFFFF_FFFF); access(0, 16, 0);
    wr_win(8'hFF, 32'hFFFF_FFFF); access(0, 16, 0);
    // R4 R6 identifier writes
    wr_win(0, 32'hFE00_0000); access(0, 16, 0);
    wr_win(2, 32'hA5FF_FFFF); access(0, 16, 0);
    // R11 illegal offsets
    access(0, 4, 0); access(1, 20, 32'hFFFF_FFFF); access(1, 8'hFF, 32'h0);
    access(0, 0, 0);
    for (int k = 0; k < 4000; k++) begin
      int unsigned op = $urandom % 10;
      logic [31:0] d = $urandom;
      if (op < 3) begin
        logic [7:0] s = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 8'h44);
        access(1, 0, {d[31:8], s});
      end else if (op < 6) access(1, 16, d);
      else if (op < 8) access(0, 16, 0);
      else if (op < 9) access(0, 0, 0);
      else access($urandom % 2 == 1, 8'($urandom | 1), d);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule